// File: doc/BRIEF.md
# Class-Pair Latency Interlock for an In-Order Decode Stage

This block sits beside the decode stage of an in-order pipeline that has one integer unit and fully pipelined floating-point units. Each cycle it receives the instruction being decoded: a class code, a destination index and two source indices. It compares the sources that the class actually reads against the destinations of older instructions that are still in flight. It holds decode with a stall until the spacing that the producer and consumer classes require has passed. When the instruction may go, it raises a one-cycle issue pulse. Because results are fully forwarded, the only spacing it enforces comes from a fixed table indexed by the producer class and the consumer class.

Every register of the integer and floating-point files has a short countdown, loaded when a producer issues. A newer writer to the same register overwrites the countdown of the older one. Integer register zero is hardwired and never creates a dependence. A flush empties all countdowns in one cycle and discards the instruction in decode. The exception is the single branch delay slot: the instruction that directly follows an issued branch always issues, even under a flush. A saturating counter reports how many cycles have stalled since reset.

Top module: `lat_interlock`

## Requirements
- R1: After reset the stall-cycle count is 0, stall and issue are low while no instruction is valid, and the first valid instruction issues in its first decode cycle.
- R2: A floating-point arithmetic result (class code 2) read by the next floating-point arithmetic instruction, through either source, costs exactly 3 stall cycles.
- R3: A floating-point arithmetic result read as the store data (source B of class code 4) by the next instruction costs exactly 2 stall cycles.
- R4: A double load result (class code 3, writes the floating-point file) costs 1 stall cycle before a floating-point arithmetic reader and 0 before a store data reader.
- R5: An integer result (class code 1) read by the next branch (class code 5) costs exactly 1 stall cycle. Integer results read by integer arithmetic, by a load base or by a store base (source A) cost 0.
- R6: Each cycle that separates producer and consumer removes one stall cycle from the table value.
- R7: A write to integer register 0 is ignored, and a read of it never stalls.
- R8: When a newer producer writes the same register as an older one still counting, the consumer's stall follows the newer producer's class and issue time only.
- R9: A flush discards the decoding instruction (no issue, no stall) unless it sits in the delay slot, and clears every countdown within that one cycle.
- R10: The instruction decoded right after an issued branch is the delay slot. It issues even with flush high, and its destination stays tracked. A cycle with no valid instruction right after the branch uses up the slot.
- R11: Stall and issue are never high together, and a valid instruction that is not discarded raises exactly one of them.
- R12: The stall-cycle count increases by one in each stall cycle, holds otherwise, and stays at its all-ones value once it gets there.
- R13: The loop body load, floating-point add, store, integer decrement, branch and an empty delay slot takes 10 cycles, with 1, 2 and 1 stall cycles before the add, the store and the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard the decoding instruction and clear all countdowns |
| dec_valid_i | input | 1 | Decode holds a valid instruction |
| dec_cls_i | input | 3 | Class: 0 none, 1 integer op, 2 FP op, 3 double load, 4 double store, 5 branch |
| dec_dst_i | input | log2(NREG) | Destination index (integer file for class 1, FP file for classes 2 and 3) |
| dec_srca_i | input | log2(NREG) | Source A: FP for class 2, integer for classes 1, 3, 4 and 5 |
| dec_srcb_i | input | log2(NREG) | Source B: FP for classes 2 and 4, integer for classes 1 and 5 |
| stall_o | output | 1 | Hold the decoding instruction this cycle |
| issue_o | output | 1 | The decoding instruction issues this cycle |
| stall_cnt_o | output | STALL_W | Saturating count of stall cycles since reset |

## Verification
The hardest situation to reach is a flush that lands exactly on the delay slot. It needs an issued branch, then a valid instruction in the very next cycle, together with a flush. The stimulus issues a branch on idle registers and drives a floating-point producer with flush in the following cycle. It then drives a dependent consumer to show that the slot's countdown survived the clear. A separate run places an idle cycle after the branch, then checks that a flush discards the next instruction. Replacement of a tracked producer is reached by putting a load to the same register between an arithmetic producer and its reader. This way the one-cycle answer differs from the three-cycle one.

// File: rtl/lat_interlock_pkg.sv
`timescale 1ns/1ps
package lat_interlock_pkg;
   typedef enum logic [2:0] {
      CLS_NONE = 3'd0,
      CLS_INT  = 3'd1,
      CLS_FPOP = 3'd2,
      CLS_LDD  = 3'd3,
      CLS_STD  = 3'd4,
      CLS_BR   = 3'd5
   } op_cls_e;
endpackage

// File: rtl/lat_interlock_sb.sv
`timescale 1ns/1ps
// One countdown and one producer tag per architectural register.
module lat_interlock_sb #(
   parameter int ENT_W     = 6,
   parameter int CNT_W     = 2,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr_i,
   input  logic                          wr_en_i,
   input  logic [ENT_W-1:0]              wr_idx_i,
   input  logic [CNT_W-1:0]              wr_cnt_i,
   input  logic                          wr_tag_i,
   output logic [2**ENT_W-1:0][CNT_W-1:0] cnt_o,
   output logic [2**ENT_W-1:0]            tag_o
);
   localparam int NENT = 2**ENT_W;

   for (genvar i = 0; i < NENT; i++) begin : g_ent
      if (HARD_ZERO && i == 0) begin : g_zero
         assign cnt_o[i] = '0;
         assign tag_o[i] = 1'b0;
      end else begin : g_live
         logic [CNT_W-1:0] cnt_q;
         logic             tag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               tag_q <= 1'b0;
            end else if (wr_en_i && wr_idx_i == ENT_W'(i)) begin
               cnt_q <= wr_cnt_i;
               tag_q <= wr_tag_i;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign cnt_o[i] = cnt_q;
         assign tag_o[i] = tag_q;
      end
   end
endmodule

// File: rtl/lat_interlock_hazard.sv
`timescale 1ns/1ps
// Source lookup and class-pair threshold compare.
module lat_interlock_hazard
   import lat_interlock_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter int CNT_W     = 2,
   parameter int LAT_FPFP  = 3,
   parameter int LAT_FPST  = 2,
   parameter int LAT_LDFP  = 1,
   parameter int LAT_LDST  = 0,
   parameter int LAT_INTBR = 1
) (
   input  logic [2:0]                             cls_i,
   input  logic [1:0][IDX_W-1:0]                  src_i,
   input  logic [2**(IDX_W+1)-1:0][CNT_W-1:0]     cnt_i,
   input  logic [2**(IDX_W+1)-1:0]                tag_i,
   output logic                                   hazard_o
);
   logic [1:0] rd_en;
   logic [1:0] rd_fp;
   logic [1:0] hit;

   function automatic int lmax_f(input logic fp, input logic ld);
      if (!fp)     return LAT_INTBR;
      else if (ld) return LAT_LDFP;
      else         return LAT_FPFP;
   endfunction

   function automatic int need_f(input logic fp, input logic ld, input logic [2:0] cls);
      if (!fp)     return (cls == CLS_BR)   ? LAT_INTBR : 0;
      else if (ld) return (cls == CLS_FPOP) ? LAT_LDFP  : LAT_LDST;
      else         return (cls == CLS_FPOP) ? LAT_FPFP  : LAT_FPST;
   endfunction

   always_comb begin
      rd_en[0] = cls_i inside {CLS_INT, CLS_FPOP, CLS_LDD, CLS_STD, CLS_BR};
      rd_fp[0] = (cls_i == CLS_FPOP);
      rd_en[1] = cls_i inside {CLS_INT, CLS_FPOP, CLS_STD, CLS_BR};
      rd_fp[1] = cls_i inside {CLS_FPOP, CLS_STD};
   end

   for (genvar s = 0; s < 2; s++) begin : g_src
      logic [IDX_W:0]   ent;
      logic [CNT_W-1:0] cnt;
      logic             ld;
      assign ent    = {rd_fp[s], src_i[s]};
      assign cnt    = cnt_i[ent];
      assign ld     = tag_i[ent];
      assign hit[s] = rd_en[s] &&
                      (int'(cnt) > lmax_f(rd_fp[s], ld) - need_f(rd_fp[s], ld, cls_i));
   end

   assign hazard_o = |hit;
endmodule

// File: rtl/lat_interlock_satcnt.sv
`timescale 1ns/1ps
module lat_interlock_satcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_o <= '0;
      else if (inc_i && cnt_o != '1)   cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/lat_interlock.sv
`timescale 1ns/1ps
module lat_interlock
   import lat_interlock_pkg::*;
#(
   parameter int NREG      = 32,
   parameter int STALL_W   = 16,
   parameter int LAT_FPFP  = 3,
   parameter int LAT_FPST  = 2,
   parameter int LAT_LDFP  = 1,
   parameter int LAT_LDST  = 0,
   parameter int LAT_INTBR = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush_i,
   input  logic                    dec_valid_i,
   input  logic [2:0]              dec_cls_i,
   input  logic [$clog2(NREG)-1:0] dec_dst_i,
   input  logic [$clog2(NREG)-1:0] dec_srca_i,
   input  logic [$clog2(NREG)-1:0] dec_srcb_i,
   output logic                    stall_o,
   output logic                    issue_o,
   output logic [STALL_W-1:0]      stall_cnt_o
);
   localparam int IDX_W    = $clog2(NREG);
   localparam int ENT_W    = IDX_W + 1;
   localparam int NENT     = 2**ENT_W;
   localparam int LMAX_FP  = (LAT_FPFP > LAT_LDFP) ? LAT_FPFP : LAT_LDFP;
   localparam int LMAX_ALL = (LMAX_FP > LAT_INTBR) ? LMAX_FP : LAT_INTBR;
   localparam int CNT_W    = $clog2(LMAX_ALL + 1);

   if (NREG < 2 || (2**IDX_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two, at least 2");
   end
   if (LAT_FPST > LAT_FPFP || LAT_LDST > LAT_LDFP) begin : g_bad_store
      $error("store latencies may not exceed the arithmetic reader latencies");
   end
   if (LAT_FPFP < 1 || LAT_LDFP < 1 || LAT_INTBR < 1) begin : g_bad_lat
      $error("producer latencies must be at least 1");
   end
   if (STALL_W < 1) begin : g_bad_cnt
      $error("STALL_W must be at least 1");
   end

   logic [NENT-1:0][CNT_W-1:0] sb_cnt;
   logic [NENT-1:0]            sb_tag;
   logic [1:0][IDX_W-1:0]      srcs;
   logic                       hazard;
   logic                       live;
   logic                       slot_q;
   logic                       wr_en;
   logic [ENT_W-1:0]           wr_idx;
   logic [CNT_W-1:0]           wr_cnt;
   logic                       wr_tag;

   assign srcs    = {dec_srcb_i, dec_srca_i};
   assign live    = dec_valid_i && (!flush_i || slot_q);
   assign stall_o = live && hazard;
   assign issue_o = live && !hazard;

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = {1'b1, dec_dst_i};
      wr_cnt = CNT_W'(LAT_FPFP);
      wr_tag = 1'b0;
      case (dec_cls_i)
         CLS_INT: begin
            wr_en  = issue_o;
            wr_idx = {1'b0, dec_dst_i};
            wr_cnt = CNT_W'(LAT_INTBR);
         end
         CLS_FPOP: wr_en = issue_o;
         CLS_LDD: begin
            wr_en  = issue_o;
            wr_cnt = CNT_W'(LAT_LDFP);
            wr_tag = 1'b1;
         end
         default: wr_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= 1'b0;
      else if (issue_o) slot_q <= (dec_cls_i == CLS_BR);
      else if (!stall_o) slot_q <= 1'b0;
   end

   lat_interlock_sb #(
      .ENT_W(ENT_W), .CNT_W(CNT_W), .HARD_ZERO(1'b1)
   ) u_sb (
      .clk(clk), .rst_n(rst_n), .clr_i(flush_i),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_cnt_i(wr_cnt), .wr_tag_i(wr_tag),
      .cnt_o(sb_cnt), .tag_o(sb_tag)
   );

   lat_interlock_hazard #(
      .IDX_W(IDX_W), .CNT_W(CNT_W),
      .LAT_FPFP(LAT_FPFP), .LAT_FPST(LAT_FPST), .LAT_LDFP(LAT_LDFP),
      .LAT_LDST(LAT_LDST), .LAT_INTBR(LAT_INTBR)
   ) u_hz (
      .cls_i(dec_cls_i), .src_i(srcs), .cnt_i(sb_cnt), .tag_i(sb_tag),
      .hazard_o(hazard)
   );

   lat_interlock_satcnt #(.W(STALL_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(stall_o), .cnt_o(stall_cnt_o)
   );
endmodule

// File: rtl/lat_interlock_chk.sv
`timescale 1ns/1ps
module lat_interlock_chk
   import lat_interlock_pkg::*;
#(
   parameter int NREG    = 32,
   parameter int STALL_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    flush_i,
   input logic                    dec_valid_i,
   input logic [2:0]              dec_cls_i,
   input logic [$clog2(NREG)-1:0] dec_dst_i,
   input logic [$clog2(NREG)-1:0] dec_srca_i,
   input logic [$clog2(NREG)-1:0] dec_srcb_i,
   input logic                    stall_o,
   input logic                    issue_o,
   input logic [STALL_W-1:0]      stall_cnt_o,
   input logic                    slot_q
);
   localparam int IDX_W = $clog2(NREG);

   logic             prev_fp;
   logic [IDX_W-1:0] prev_dst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_fp  <= 1'b0;
         prev_dst <= '0;
      end else begin
         prev_fp  <= issue_o && (dec_cls_i == CLS_FPOP);
         prev_dst <= dec_dst_i;
      end
   end

   // R11
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(stall_o && issue_o));
   a_r11_one_of: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_i && !flush_i) |-> (stall_o || issue_o));
   // R9
   a_r9_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && !slot_q) |-> (!issue_o && !stall_o));
   // R2
   a_r2_fp_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_fp && dec_valid_i && !flush_i && dec_cls_i == CLS_FPOP &&
       (dec_srca_i == prev_dst || dec_srcb_i == prev_dst)) |-> stall_o);
   // R3
   a_r3_fp_store: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_fp && dec_valid_i && !flush_i && dec_cls_i == CLS_STD &&
       dec_srcb_i == prev_dst) |-> stall_o);
   // R5
   a_r5_int_free: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_cls_i == CLS_INT || dec_cls_i == CLS_LDD) |-> !stall_o);
   // R7
   a_r7_zero_branch: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_cls_i == CLS_BR && dec_srca_i == '0 && dec_srcb_i == '0) |-> !stall_o);
   // R12
   a_r12_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && stall_cnt_o != {STALL_W{1'b1}}) |=>
      (stall_cnt_o == STALL_W'($past(stall_cnt_o) + 1'b1)));
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_o |=> $stable(stall_cnt_o));
   a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_cnt_o == {STALL_W{1'b1}}) |=> (stall_cnt_o == {STALL_W{1'b1}}));
endmodule

bind lat_interlock lat_interlock_chk #(.NREG(NREG), .STALL_W(STALL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .dec_valid_i(dec_valid_i),
   .dec_cls_i(dec_cls_i), .dec_dst_i(dec_dst_i), .dec_srca_i(dec_srca_i),
   .dec_srcb_i(dec_srcb_i), .stall_o(stall_o), .issue_o(issue_o),
   .stall_cnt_o(stall_cnt_o), .slot_q(slot_q)
);

// File: tb/lat_interlock_tb.sv
`timescale 1ns/1ps
module lat_interlock_tb;
   import lat_interlock_pkg::*;

   localparam int IDX_W   = 5;
   localparam int STALL_W = 5;
   localparam int CMAX    = 31;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             flush_i = 1'b0;
   logic             dec_valid_i = 1'b0;
   logic [2:0]       dec_cls_i = 3'd0;
   logic [IDX_W-1:0] dec_dst_i = '0;
   logic [IDX_W-1:0] dec_srca_i = '0;
   logic [IDX_W-1:0] dec_srcb_i = '0;
   logic             stall_o;
   logic             issue_o;
   logic [STALL_W-1:0] stall_cnt_o;

   int n_chk = 0;
   int n_bad = 0;
   int obs_stalls = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lat_interlock #(.NREG(32), .STALL_W(STALL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .dec_valid_i(dec_valid_i),
      .dec_cls_i(dec_cls_i), .dec_dst_i(dec_dst_i), .dec_srca_i(dec_srca_i),
      .dec_srcb_i(dec_srcb_i), .stall_o(stall_o), .issue_o(issue_o),
      .stall_cnt_o(stall_cnt_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input bit v, input op_cls_e c, input int d, input int a,
                        input int b, input bit fl);
      dec_valid_i = v;
      dec_cls_i   = c;
      dec_dst_i   = IDX_W'(d);
      dec_srca_i  = IDX_W'(a);
      dec_srcb_i  = IDX_W'(b);
      flush_i     = fl;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         drive(1'b0, CLS_NONE, 0, 0, 0, 1'b0);
      end
   endtask

   // Hold one instruction in decode until it issues; returns stall cycles seen.
   task automatic put(input op_cls_e c, input int d, input int a, input int b,
                      input int exp, input string req, output int st);
      bit done = 1'b0;
      st = 0;
      for (int k = 0; k < 12 && !done; k++) begin
         @(negedge clk);
         drive(1'b1, c, d, a, b, 1'b0);
         #1;
         if (stall_o === issue_o) chk(1'b0, "R11 one of stall/issue", int'(stall_o), int'(!issue_o));
         if (stall_o) obs_stalls++;
         if (issue_o) done = 1'b1;
         else st++;
      end
      if (exp >= 0) chk(done && st == exp, req, st, exp);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic t_reset();
      int st;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!stall_o && !issue_o, "R1 outputs idle after reset", int'(stall_o) + int'(issue_o), 0);
      chk(stall_cnt_o == 0, "R1 stall count zero", int'(stall_cnt_o), 0);
      put(CLS_FPOP, 2, 4, 6, 0, "R1 first instruction issues at once", st);
   endtask

   task automatic t_fp_pairs();
      int st;
      put(CLS_FPOP, 8, 2, 10, 3, "R2 FP op after FP op via source A", st);
      idle(1);
      #1;
      chk(stall_cnt_o == 3, "R12 count after three stalls", int'(stall_cnt_o), 3);
      idle(5);
      put(CLS_FPOP, 12, 4, 6, 0, "R2 setup", st);
      put(CLS_FPOP, 14, 16, 12, 3, "R2 FP op after FP op via source B", st);
      idle(5);
      put(CLS_FPOP, 4, 0, 2, 0, "R3 setup", st);
      put(CLS_STD, 0, 1, 4, 2, "R3 store data after FP op", st);
   endtask

   task automatic t_load();
      int st;
      idle(5);
      put(CLS_LDD, 0, 1, 0, 0, "R4 setup", st);
      put(CLS_FPOP, 4, 0, 2, 1, "R4 FP op after load", st);
      idle(5);
      put(CLS_LDD, 6, 1, 0, 0, "R4 setup", st);
      put(CLS_STD, 0, 1, 6, 0, "R4 store data after load", st);
   endtask

   task automatic t_int();
      int st;
      idle(5);
      put(CLS_INT, 3, 1, 2, 0, "R5 setup", st);
      put(CLS_BR, 0, 3, 0, 1, "R5 branch after integer op", st);
      put(CLS_INT, 5, 7, 8, 0, "R5 slot integer op", st);
      put(CLS_LDD, 1, 5, 0, 0, "R5 load base after integer op", st);
      put(CLS_INT, 9, 1, 2, 0, "R5 setup", st);
      put(CLS_STD, 0, 9, 20, 0, "R5 store base after integer op", st);
      put(CLS_INT, 10, 11, 12, 0, "R5 setup", st);
      put(CLS_INT, 13, 10, 10, 0, "R5 integer op after integer op", st);
      idle(5);
      put(CLS_INT, 0, 1, 2, 0, "R7 write to r0", st);
      put(CLS_BR, 0, 0, 0, 0, "R7 branch reading r0", st);
   endtask

   task automatic t_gap();
      int st;
      idle(5);
      put(CLS_FPOP, 2, 4, 6, 0, "R6 setup", st);
      idle(1);
      put(CLS_FPOP, 8, 2, 10, 2, "R6 one idle cycle between", st);
      idle(5);
      put(CLS_FPOP, 2, 4, 6, 0, "R6 setup", st);
      idle(2);
      put(CLS_FPOP, 8, 2, 10, 1, "R6 two idle cycles between", st);
   endtask

   task automatic t_replace();
      int st;
      idle(5);
      put(CLS_FPOP, 2, 4, 6, 0, "R8 setup", st);
      put(CLS_LDD, 2, 1, 0, 0, "R8 newer load to same register", st);
      put(CLS_FPOP, 8, 2, 10, 1, "R8 reader follows newer producer", st);
   endtask

   task automatic t_flush();
      int st;
      idle(5);
      put(CLS_FPOP, 2, 4, 6, 0, "R9 setup", st);
      @(negedge clk);
      drive(1'b1, CLS_FPOP, 8, 2, 10, 1'b1);
      #1;
      chk(!issue_o && !stall_o, "R9 flushed instruction discarded",
          int'(issue_o) + int'(stall_o), 0);
      put(CLS_FPOP, 8, 2, 10, 0, "R9 countdowns cleared by flush", st);
   endtask

   task automatic t_slot();
      int st;
      idle(5);
      put(CLS_BR, 0, 6, 7, 0, "R10 setup", st);
      @(negedge clk);
      drive(1'b1, CLS_FPOP, 2, 4, 6, 1'b1);
      #1;
      chk(issue_o == 1'b1, "R10 slot instruction issues under flush", int'(issue_o), 1);
      put(CLS_FPOP, 8, 2, 10, 3, "R10 slot result still tracked", st);
      idle(5);
      put(CLS_BR, 0, 6, 7, 0, "R10 setup", st);
      idle(1);
      @(negedge clk);
      drive(1'b1, CLS_FPOP, 2, 4, 6, 1'b1);
      #1;
      chk(!issue_o, "R10 empty slot is used up", int'(issue_o), 0);
   endtask

   task automatic t_loop();
      int st;
      int total;
      idle(5);
      total = 0;
      put(CLS_LDD, 0, 1, 0, 0, "R13 load", st);        total += 1 + st;
      put(CLS_FPOP, 4, 0, 2, 1, "R13 add", st);        total += 1 + st;
      put(CLS_STD, 0, 1, 4, 2, "R13 store", st);       total += 1 + st;
      put(CLS_INT, 1, 1, 0, 0, "R13 decrement", st);   total += 1 + st;
      put(CLS_BR, 0, 1, 2, 1, "R13 branch", st);       total += 1 + st;
      idle(1);                                          total += 1;
      chk(total == 10, "R13 cycles per iteration", total, 10);
   endtask

   task automatic t_sat();
      int st;
      int exp;
      for (int k = 0; k < 10; k++) begin
         idle(4);
         put(CLS_FPOP, 2, 4, 6, 0, "R12 setup", st);
         put(CLS_FPOP, 8, 2, 10, 3, "R2 chain", st);
      end
      idle(1);
      #1;
      exp = (obs_stalls > CMAX) ? CMAX : obs_stalls;
      chk(int'(stall_cnt_o) == exp, "R12 count saturates", int'(stall_cnt_o), exp);
      chk(obs_stalls > CMAX, "R12 saturation reached", obs_stalls, CMAX + 1);
      put(CLS_FPOP, 2, 4, 6, 0, "R12 setup", st);
      put(CLS_FPOP, 8, 2, 10, 3, "R12 chain", st);
      idle(1);
      #1;
      chk(int'(stall_cnt_o) == CMAX, "R12 stays at all ones", int'(stall_cnt_o), CMAX);
   endtask

   initial begin
      t_reset();
      t_fp_pairs();
      t_load();
      t_int();
      t_gap();
      t_replace();
      t_flush();
      t_slot();
      t_loop();
      t_sat();
      idle(2);
      summary();
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
   end
endmodule